// File: doc/BRIEF.md
# Multi-Channel Serial Pattern Generator

This block drives several independent serial pattern channels. Each channel has a pattern clock line and a pattern data line. When its enable is raised, the channel loads a 64-bit pattern word and shifts it out least significant bit first. The number of bits is programmable. Each channel uses its own divider, so the pattern clock of one channel has a period that is independent of the others.

A polarity input picks the active edge of each channel's clock. Data changes only on the opposite edge, so it is stable when the receiver samples it. When the last bit has been presented, the channel sets a sticky done interrupt bit and returns both of its lines low. It then waits until its enable is dropped and raised again before it sends another pattern.

The configuration is taken straight from input ports. Software logic outside the block owns those registers.

Top module: `patgen_multi`

## Requirements
- R1: While reset is active and straight after it, every pattern clock line, pattern data line and done interrupt bit is 0.
- R2: With polarity 0 the data bit is sampled at a rising edge of the channel clock. With polarity 1 it is sampled at a falling edge. The line idles low for both polarities.
- R3: Consecutive active edges of a channel's clock are exactly `div` system clock cycles apart. A divider value below 2 behaves as 2.
- R4: A channel emits exactly `len_m1 + 1` bits (1 to 64), taken from its pattern word starting at bit 0 and moving upward.
- R5: The done bit of a channel is set at the same system clock edge as the last active edge. It is therefore already 1 when the last bit is sampled, and it is 0 at every earlier active edge.
- R6: After the last bit, both lines of the channel stay low and no new pattern starts while enable stays high.
- R7: Dropping enable in the middle of a pattern drives both lines low one cycle later and never sets the done bit.
- R8: The done bit stays set until a cycle in which the channel's `done_clr` bit is 1. That write clears it.
- R9: Data changes only at the inactive clock edge. The data value one cycle before an active edge equals the value at that edge.
- R10: Channels run concurrently with different polarity, divider and length and do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | NCH | Per-channel enable; a rising request starts a pattern |
| pol | input | NCH | Per-channel polarity: 0 = rising active edge, 1 = falling |
| div | input | NCH*DW | Per-channel divider, system cycles per pattern clock period |
| len_m1 | input | NCH*LW | Per-channel pattern length minus one |
| pattern | input | NCH*PW | Per-channel pattern word, sent from bit 0 upward |
| done_clr | input | NCH | Per-channel write-one-to-clear for the done bit |
| done_irq | output | NCH | Sticky per-channel done interrupt |
| pat_clk | output | NCH | Per-channel pattern clock |
| pat_dat | output | NCH | Per-channel pattern data |

## Verification
Each internal fault shows up at the ports within one pattern clock period.
- A wrong shift register or bit index shows up as the wrong data bit at the next active edge, or as an extra or missing edge. Both appear as soon as the pattern reaches the bad bit.
- A phase counter that wraps at the wrong count shifts the edge spacing at the first full period.
- A bad completion condition shows as a done bit that is late or early relative to the last sampled bit, or as a pattern that restarts while enable is held.

// File: rtl/patgen_multi.sv
module patgen_multi #(
  parameter int NCH = 2,
  parameter int DW  = 16,
  parameter int PW  = 64,
  parameter int LW  = $clog2(PW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    en,
  input  logic [NCH-1:0]    pol,
  input  logic [NCH*DW-1:0] div,
  input  logic [NCH*LW-1:0] len_m1,
  input  logic [NCH*PW-1:0] pattern,
  input  logic [NCH-1:0]    done_clr,
  output logic [NCH-1:0]    done_irq,
  output logic [NCH-1:0]    pat_clk,
  output logic [NCH-1:0]    pat_dat
);

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_RUN  = 2'd1;
  localparam logic [1:0] ST_HALT = 2'd2;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [1:0]    st_q;
    logic [DW-1:0] cnt_q;
    logic [LW-1:0] idx_q;
    logic [PW-1:0] sh_q;
    logic          done_q;

    wire [DW-1:0] div_c  = div[c*DW +: DW];
    wire [DW-1:0] deff   = (div_c < DW'(2)) ? DW'(2) : div_c;
    wire [DW-1:0] half   = deff >> 1;
    wire          run    = (st_q == ST_RUN);
    wire          last   = (idx_q == len_m1[c*LW +: LW]);
    wire          wrap   = (cnt_q == deff - DW'(1));
    wire          act    = (cnt_q >= half);
    wire          set_dn = run && en[c] && last && (cnt_q == half - DW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
        idx_q <= '0;
        sh_q  <= '0;
      end else begin
        case (st_q)
          ST_IDLE: if (en[c]) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= pattern[c*PW +: PW];
          end
          ST_RUN: begin
            if (!en[c]) begin
              st_q <= ST_IDLE;
            end else if (wrap) begin
              cnt_q <= '0;
              if (last) begin
                st_q <= ST_HALT;
              end else begin
                idx_q <= idx_q + LW'(1);
                sh_q  <= sh_q >> 1;
              end
            end else begin
              cnt_q <= cnt_q + DW'(1);
            end
          end
          default: if (!en[c]) st_q <= ST_IDLE;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= (done_q && !done_clr[c]) || set_dn;
    end

    assign done_irq[c] = done_q;
    assign pat_clk[c]  = run && (act ^ pol[c]);
    assign pat_dat[c]  = run && sh_q[0];

    AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      !en[c] |=> (!pat_clk[c] && !pat_dat[c])); // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_irq[c] && !done_clr[c]) |=> done_irq[c]); // R8
    AST_DONE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_irq[c]) |-> $past(en[c])); // R7
    AST_CLR_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_clr[c] && !run) |=> !done_irq[c]); // R8
    AST_HALT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HALT) |-> (!pat_clk[c] && !pat_dat[c])); // R6
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $rose(act)) |-> $stable(pat_dat[c])); // R9
  end

endmodule

// File: tb/patgen_multi_bench.sv
module patgen_multi_bench;
  localparam int NCH = 2;
  localparam int DW  = 16;
  localparam int PW  = 64;
  localparam int LW  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    en = '0;
  logic [NCH-1:0]    pol = '0;
  logic [NCH*DW-1:0] div = '0;
  logic [NCH*LW-1:0] len_m1 = '0;
  logic [NCH*PW-1:0] pattern = '0;
  logic [NCH-1:0]    done_clr = '0;
  logic [NCH-1:0]    done_irq, pat_clk, pat_dat;

  int checks = 0;
  int failures = 0;

  bit exp_q[NCH][$];
  bit mon_on[NCH];
  bit seen[NCH];
  bit prev_clk[NCH];
  bit prev_dat[NCH];
  int cyc[NCH];
  int exp_div[NCH];

  always #10 clk = ~clk;

  patgen_multi #(.NCH(NCH), .DW(DW), .PW(PW), .LW(LW)) u_patgen_multi (
    .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .div(div), .len_m1(len_m1),
    .pattern(pattern), .done_clr(done_clr), .done_irq(done_irq),
    .pat_clk(pat_clk), .pat_dat(pat_dat)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        cyc[c]++;
        if (mon_on[c]) begin
          bit edge_seen;
          edge_seen = pol[c] ? (prev_clk[c] && !pat_clk[c]) : (!prev_clk[c] && pat_clk[c]);
          if (edge_seen) begin
            if (exp_q[c].size() == 0) begin
              chk(1'b0, "R4 extra active edge", 1, 0);
            end else begin
              bit e;
              e = exp_q[c].pop_front();
              chk(pat_dat[c] == e, "R2 R4 data bit at active edge", pat_dat[c], e);
              chk(prev_dat[c] == pat_dat[c], "R9 data stable before edge", prev_dat[c], pat_dat[c]);
              if (seen[c]) chk(cyc[c] == exp_div[c], "R3 active edge spacing", cyc[c], exp_div[c]);
              chk(done_irq[c] == (exp_q[c].size() == 0), "R5 done timing",
                  done_irq[c], exp_q[c].size() == 0);
            end
            seen[c] = 1'b1;
            cyc[c]  = 0;
          end
        end
        prev_clk[c] = pat_clk[c];
        prev_dat[c] = pat_dat[c];
      end
    end
  end

  task automatic setup(input int ch, input bit p, input int d, input int len, input logic [63:0] w);
    pol[ch] = p;
    div[ch*DW +: DW] = DW'(d);
    len_m1[ch*LW +: LW] = LW'(len - 1);
    pattern[ch*PW +: PW] = w;
    exp_div[ch] = (d < 2) ? 2 : d;
    seen[ch] = 1'b0;
    for (int i = 0; i < len; i++) exp_q[ch].push_back(w[i]);
    mon_on[ch] = 1'b1;
  endtask

  task automatic run_pattern(input int ch, input bit p, input int d, input int len,
                             input logic [63:0] w, input string tag);
    @(negedge clk);
    setup(ch, p, d, len, w);
    en[ch] = 1'b1;
    while (exp_q[ch].size() != 0) @(negedge clk);
    chk(done_irq[ch] == 1'b1, {tag, " R5 done after last bit"}, done_irq[ch], 1);
    for (int k = 0; k < 3 * exp_div[ch] + 2; k++) @(negedge clk);
    chk(pat_clk[ch] == 1'b0 && pat_dat[ch] == 1'b0, {tag, " R6 lines low after pattern"},
        {pat_clk[ch], pat_dat[ch]}, 0);
    chk(exp_q[ch].size() == 0 && done_irq[ch], {tag, " R6 no restart, R8 done held"},
        done_irq[ch], 1);
    mon_on[ch] = 1'b0;
    en[ch] = 1'b0;
    @(negedge clk);
    done_clr[ch] = 1'b1;
    @(negedge clk);
    done_clr[ch] = 1'b0;
    chk(done_irq[ch] == 1'b0, {tag, " R8 done cleared"}, done_irq[ch], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pat_clk == '0 && pat_dat == '0 && done_irq == '0, "R1 outputs in reset",
        {pat_clk, pat_dat, done_irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pat_clk == '0 && pat_dat == '0 && done_irq == '0, "R1 outputs after reset",
        {pat_clk, pat_dat, done_irq}, 0);

    run_pattern(0, 1'b0, 4, 8, 64'h0000_0000_0000_00B5, "pol0 div4 len8");
    run_pattern(1, 1'b1, 5, 64, 64'hA5C3_0F1E_9966_7E81, "pol1 div5 len64");
    run_pattern(0, 1'b1, 1, 1, 64'h1, "div1 len1");
    run_pattern(1, 1'b0, 2, 3, 64'h5, "div2 len3");

    fork
      run_pattern(0, 1'b1, 3, 20, 64'h000F_3C5A, "R10 ch0 concurrent");
      run_pattern(1, 1'b0, 7, 9, 64'h1AB, "R10 ch1 concurrent");
    join

    @(negedge clk);
    setup(0, 1'b0, 4, 20, 64'hFFFF_FFFF);
    en[0] = 1'b1;
    repeat (30) @(negedge clk);
    mon_on[0] = 1'b0;
    en[0] = 1'b0;
    @(negedge clk);
    chk(pat_clk[0] == 1'b0 && pat_dat[0] == 1'b0, "R7 abort lines low",
        {pat_clk[0], pat_dat[0]}, 0);
    repeat (100) @(negedge clk);
    chk(done_irq[0] == 1'b0, "R7 abort without done", done_irq[0], 0);
    exp_q[0].delete();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule